// File: doc/BRIEF.md
# Burst Bus Master Sequencer

This block is a bus-master transfer engine. It takes one operand request and turns it into a series of data beats on an external bus whose port can be 8, 16 or 32 bits wide. The operand is a byte, a word, a longword or a whole 16-byte line. The requester supplies the start address, the operand size, the direction, the port width of the target, a burst-enable flag and the write data. The engine then drives the address, a two-bit size code, the beat strobes and the data lanes for each beat.

Every beat ends on a clock edge where the active-low transfer acknowledge is sampled low. While it stays high, the engine holds the beat unchanged and adds wait states. Read data is assembled big-endian from the upper lanes. When the final beat has been acknowledged, the engine pulses a done flag.

The size code depends on the burst flag. With bursting allowed, every beat carries the code of the whole operand. With bursting inhibited, each beat carries the code of the amount of data it really moves, which is never wider than the port.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, bus_act, bus_doe and rsp_done are 0 and req_rdy is 1.
- R2: A request is accepted only on a clock edge where req_rdy is 1 and req_valid is 1. bus_act then rises in the next cycle. A req_valid raised while a transfer runs has no effect, and no beat or done flag comes from it.
- R3: req_op encodes the operand: 00 byte (1 byte), 01 word (2 bytes), 10 longword (4 bytes), 11 line (16 bytes). req_port encodes the port: 00 8-bit, 01 16-bit, 10 or 11 32-bit. Each beat moves min(operand, port) bytes, so the transfer has operand/beat-bytes beats. A line to an 8-bit port takes 16 beats.
- R4: On a clock edge where bus_ta_n is 1 during a transfer, the beat is not finished. bus_addr, bus_siz and bus_dout stay unchanged in the next cycle.
- R5: For a non-line operand, beat i uses address req_addr + i*beat-bytes. For a line, the first beat uses req_addr with bits [1:0] cleared. Bits [3:0] then advance by the beat size and wrap to 0 within the 16-byte block, and the upper bits stay fixed.
- R6: With req_burst = 1, bus_siz on every beat is the operand code: byte 01, word 10, longword 00, line 11.
- R7: With req_burst = 0, bus_siz on every beat is the code of the beat size: 1 byte 01, 2 bytes 10, 4 bytes 00.
- R8: The operand to write sits in the low operand-bytes of req_wdata. Each write beat places its bytes on the upper lanes, starting at bus_dout[31:24], with the most significant remaining operand byte first. Unused lanes are 0. bus_doe is 1 exactly while a write transfer is active, and bus_dout is 0 otherwise.
- R9: At rsp_done, rsp_rdata holds a read operand right-justified. The first beat lands in the most significant bytes, and each beat is taken from the upper lanes, starting at bus_din[31:24]. After a write, rsp_rdata is 0.
- R10: rsp_done is 1 for exactly the one cycle after the edge that acknowledges the last beat. In that cycle req_rdy is 1 and a new request can be accepted.
- R11: bus_ts is 1 in the first cycle of each beat and 0 in the wait cycles.
- R12: bus_rw is 1 for a read transfer and 0 for a write transfer while bus_act is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_rdy | output | 1 | Engine idle and able to accept |
| req_addr | input | ADDR_W | Operand start address |
| req_op | input | 2 | Operand size code |
| req_port | input | 2 | Port width code of the target |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | Bursting allowed |
| req_wdata | input | 8*LINE_BYTES | Write operand, right-justified |
| bus_act | output | 1 | Transfer in progress |
| bus_ts | output | 1 | First cycle of a beat |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_addr | output | ADDR_W | Beat address |
| bus_siz | output | 2 | Size code |
| bus_doe | output | 1 | Data lanes driven |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ta_n | input | 1 | Transfer acknowledge, active low |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*LINE_BYTES | Assembled read operand |

## Verification
A beat counter that is off by one shows at the ports as bus_act ending too early or running on, and this is visible in the cycle after the last acknowledge. A wrong address offset register shows as an address mismatch on the next beat. A line that does not wrap shows as a carry into bit 4 at the beat after the last longword of the block. The write shift state and the read assembly state are not visible until a lane is driven or rsp_done rises, so a slice error in them appears on the beat it affects or at completion. A size code latched from the wrong table shows on the first cycle of the transfer.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
   localparam int LG_W  = 3;
   localparam int BUS_W = 32;
   localparam int BUS_B = BUS_W / 8;

   typedef enum logic [1:0] {
      OP_BYTE = 2'd0,
      OP_WORD = 2'd1,
      OP_LONG = 2'd2,
      OP_LINE = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      PORT8   = 2'd0,
      PORT16  = 2'd1,
      PORT32  = 2'd2,
      PORT32X = 2'd3
   } port_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_st_e;

   localparam logic [1:0] SIZ_BYTE = 2'b01;
   localparam logic [1:0] SIZ_WORD = 2'b10;
   localparam logic [1:0] SIZ_LONG = 2'b00;
   localparam logic [1:0] SIZ_LINE = 2'b11;

   // size code for an amount of 2**lg bytes
   function automatic logic [1:0] siz_of_lg(input logic [LG_W-1:0] lg);
      case (lg)
         3'd0:    return SIZ_BYTE;
         3'd1:    return SIZ_WORD;
         3'd2:    return SIZ_LONG;
         default: return SIZ_LINE;
      endcase
   endfunction
endpackage

// File: rtl/bseq_plan.sv
module bseq_plan
   import bseq_pkg::*;
#(
   parameter int LINE_LG = 4,
   parameter int CNT_W   = 4
) (
   input  op_e               op,
   input  port_e             port,
   input  logic              burst,
   output logic [LG_W-1:0]   ob_lg,
   output logic [LG_W-1:0]   bb_lg,
   output logic [CNT_W-1:0]  last_idx,
   output logic [1:0]        siz
);
   logic [LG_W-1:0] ob;
   logic [LG_W-1:0] pb;
   logic [LG_W-1:0] bb;
   int              span;

   always_comb begin
      case (op)
         OP_BYTE: ob = 3'd0;
         OP_WORD: ob = 3'd1;
         OP_LONG: ob = 3'd2;
         default: ob = LG_W'(LINE_LG);
      endcase
      case (port)
         PORT8:   pb = 3'd0;
         PORT16:  pb = 3'd1;
         default: pb = 3'd2;
      endcase
      bb       = (ob < pb) ? ob : pb;
      span     = (1 << (ob - bb)) - 1;
      last_idx = CNT_W'(span);
      siz      = burst ? siz_of_lg(ob) : siz_of_lg(bb);
      ob_lg    = ob;
      bb_lg    = bb;
   end
endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
   import bseq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              is_line,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LG_W-1:0]   ob_lg,
   input  logic [LG_W-1:0]   bb_lg,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] a_q;
   logic [ADDR_W-1:0] wrap_mask;
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] a_nxt;

   always_comb begin
      wrap_mask = (ADDR_W'(1) << ob_lg) - ADDR_W'(1);
      inc       = ADDR_W'(1) << bb_lg;
      a_nxt     = (a_q & ~wrap_mask) | ((a_q + inc) & wrap_mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
      end else if (load) begin
         a_q <= is_line ? (ld_addr & ~ADDR_W'(3)) : ld_addr;
      end else if (step) begin
         a_q <= a_nxt;
      end
   end

   assign addr = a_q;
endmodule

// File: rtl/bseq_lanes.sv
module bseq_lanes
   import bseq_pkg::*;
#(
   parameter int LINE_BYTES = 16,
   localparam int OPW  = 8 * LINE_BYTES,
   localparam int SH_W = $clog2(OPW) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic             capture,
   input  logic             drive,
   input  logic [OPW-1:0]   ld_wdata,
   input  logic [LG_W-1:0]  ob_lg,
   input  logic [LG_W-1:0]  bb_lg,
   input  logic [BUS_W-1:0] din,
   output logic [BUS_W-1:0] dout,
   output logic [OPW-1:0]   rdata
);
   logic [OPW-1:0]   wsh_q;
   logic [OPW-1:0]   rasm_q;
   logic [BUS_B-1:0] lane_en;
   logic [BUS_W-1:0] lane_mask;
   logic [BUS_W-1:0] rd_beat;
   logic [SH_W-1:0]  beat_sh;
   logic [SH_W-1:0]  ld_sh;

   // lane g counts from the most significant byte lane down
   for (genvar g = 0; g < BUS_B; g++) begin : g_lane
      assign lane_en[g] = (32'(g) < (32'd1 << bb_lg));
      assign lane_mask[BUS_W-1-8*g -: 8] = {8{lane_en[g]}};
   end

   assign beat_sh = SH_W'(8) << bb_lg;
   assign ld_sh   = SH_W'(OPW) - (SH_W'(8) << ob_lg);

   always_comb begin
      case (bb_lg)
         3'd0:    rd_beat = {24'b0, din[31:24]};
         3'd1:    rd_beat = {16'b0, din[31:16]};
         default: rd_beat = din;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsh_q  <= '0;
         rasm_q <= '0;
      end else if (load) begin
         wsh_q  <= ld_wdata << ld_sh;
         rasm_q <= '0;
      end else begin
         if (shift)   wsh_q  <= wsh_q << beat_sh;
         if (capture) rasm_q <= (rasm_q << beat_sh) | OPW'(rd_beat);
      end
   end

   assign dout  = drive ? (wsh_q[OPW-1 -: BUS_W] & lane_mask) : '0;
   assign rdata = rasm_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import bseq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   localparam int LINE_LG = $clog2(LINE_BYTES),
   localparam int CNT_W   = LINE_LG,
   localparam int OPW     = 8 * LINE_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_rdy,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_op,
   input  logic [1:0]        req_port,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic [OPW-1:0]    req_wdata,
   output logic              bus_act,
   output logic              bus_ts,
   output logic              bus_rw,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [1:0]        bus_siz,
   output logic              bus_doe,
   output logic [31:0]       bus_dout,
   input  logic [31:0]       bus_din,
   input  logic              bus_ta_n,
   output logic              rsp_done,
   output logic [OPW-1:0]    rsp_rdata
);
   if (LINE_BYTES < 8 || LINE_BYTES > 64 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("burst_seq: LINE_BYTES must be a power of two from 8 to 64");
   end
   if (ADDR_W <= LINE_LG) begin : g_bad_addr
      $error("burst_seq: ADDR_W must exceed the line offset width");
   end

   seq_st_e          st_q;
   logic [LG_W-1:0]  p_ob, p_bb, ob_q, bb_q, cur_ob, cur_bb;
   logic [CNT_W-1:0] p_last, left_q;
   logic [1:0]       p_siz, siz_q;
   logic             rw_q, ts_q, done_q;
   logic             accept, ack, fin;

   assign accept = (st_q == ST_IDLE) && req_valid;
   assign ack    = (st_q == ST_RUN) && !bus_ta_n;
   assign fin    = ack && (left_q == '0);
   assign cur_ob = (st_q == ST_IDLE) ? p_ob : ob_q;
   assign cur_bb = (st_q == ST_IDLE) ? p_bb : bb_q;

   bseq_plan #(.LINE_LG(LINE_LG), .CNT_W(CNT_W)) u_plan (
      .op       (op_e'(req_op)),
      .port     (port_e'(req_port)),
      .burst    (req_burst),
      .ob_lg    (p_ob),
      .bb_lg    (p_bb),
      .last_idx (p_last),
      .siz      (p_siz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ob_q   <= '0;
         bb_q   <= '0;
         left_q <= '0;
         siz_q  <= '0;
         rw_q   <= 1'b1;
         ts_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= fin;
         if (accept) begin
            st_q   <= ST_RUN;
            ob_q   <= p_ob;
            bb_q   <= p_bb;
            left_q <= p_last;
            siz_q  <= p_siz;
            rw_q   <= !req_write;
            ts_q   <= 1'b1;
         end else if (st_q == ST_RUN) begin
            if (ack) begin
               ts_q <= !fin;
               if (fin) st_q   <= ST_IDLE;
               else     left_q <= left_q - CNT_W'(1);
            end else begin
               ts_q <= 1'b0;
            end
         end
      end
   end

   bseq_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .step    (ack),
      .is_line (req_op == OP_LINE),
      .ld_addr (req_addr),
      .ob_lg   (cur_ob),
      .bb_lg   (cur_bb),
      .addr    (bus_addr)
   );

   bseq_lanes #(.LINE_BYTES(LINE_BYTES)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .shift    (ack),
      .capture  (ack && rw_q),
      .drive    (bus_doe),
      .ld_wdata (req_wdata),
      .ob_lg    (cur_ob),
      .bb_lg    (cur_bb),
      .din      (bus_din),
      .dout     (bus_dout),
      .rdata    (rsp_rdata)
   );

   assign req_rdy  = (st_q == ST_IDLE);
   assign bus_act  = (st_q == ST_RUN);
   assign bus_ts   = ts_q && bus_act;
   assign bus_rw   = rw_q;
   assign bus_siz  = siz_q;
   assign bus_doe  = bus_act && !rw_q;
   assign rsp_done = done_q;
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   localparam int LINE_LG = $clog2(LINE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_rdy,
   input logic              bus_act,
   input logic              bus_ts,
   input logic              bus_rw,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_siz,
   input logic              bus_doe,
   input logic [31:0]       bus_dout,
   input logic              bus_ta_n,
   input logic              rsp_done
);
   logic [LINE_LG+1:0] acks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     acks_q <= '0;
      else if (req_rdy && req_valid)  acks_q <= '0;
      else if (bus_act && !bus_ta_n)  acks_q <= acks_q + 1'b1;
   end

   // R3
   beat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acks_q <= (LINE_LG+2)'(LINE_BYTES));

   // R4
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act && bus_ta_n) |=> (bus_act && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

   // R11
   ts_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act && bus_ta_n) |=> !bus_ts);

   // R11
   ts_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act && !bus_ta_n) |=> (bus_ts || rsp_done));

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rdy && req_valid) |=> (bus_act && bus_ts));

   // R2
   rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_act |-> !req_rdy);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R10
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ($past(bus_act) && !$past(bus_ta_n) && !bus_act));

   // R8
   doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (bus_act && !bus_rw));

   // R5
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act && $past(bus_act)) |-> (bus_addr[ADDR_W-1:LINE_LG] == $past(bus_addr[ADDR_W-1:LINE_LG])));
endmodule

bind burst_seq bseq_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_rdy   (req_rdy),
   .bus_act   (bus_act),
   .bus_ts    (bus_ts),
   .bus_rw    (bus_rw),
   .bus_addr  (bus_addr),
   .bus_siz   (bus_siz),
   .bus_doe   (bus_doe),
   .bus_dout  (bus_dout),
   .bus_ta_n  (bus_ta_n),
   .rsp_done  (rsp_done)
);

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;
   localparam int OPW = 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_rdy;
   logic [31:0]    req_addr = '0;
   logic [1:0]     req_op = '0;
   logic [1:0]     req_port = '0;
   logic           req_write = 1'b0;
   logic           req_burst = 1'b0;
   logic [OPW-1:0] req_wdata = '0;
   logic           bus_act, bus_ts, bus_rw, bus_doe, rsp_done;
   logic [31:0]    bus_addr, bus_dout;
   logic [1:0]     bus_siz;
   logic [31:0]    bus_din = '0;
   logic           bus_ta_n = 1'b1;
   logic [OPW-1:0] rsp_rdata;

   always #2.5 clk = ~clk;

   burst_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rdy(req_rdy),
      .req_addr(req_addr), .req_op(req_op), .req_port(req_port),
      .req_write(req_write), .req_burst(req_burst), .req_wdata(req_wdata),
      .bus_act(bus_act), .bus_ts(bus_ts), .bus_rw(bus_rw), .bus_addr(bus_addr),
      .bus_siz(bus_siz), .bus_doe(bus_doe), .bus_dout(bus_dout),
      .bus_din(bus_din), .bus_ta_n(bus_ta_n), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state
   bit             m_run = 0, m_ts = 0, m_done = 0, m_wr = 0, m_bu = 0, m_waited = 0;
   int             m_ob, m_bb, m_beats, m_idx;
   logic [1:0]     e_siz;
   logic [31:0]    e_addr [64];
   logic [31:0]    e_dout [64];
   logic [OPW-1:0] m_rdata = '0, e_rdata = '0;

   task automatic chk(input bit ok, input string tag, input logic [OPW-1:0] act, input logic [OPW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   function automatic logic [1:0] code_of(input int n);
      case (n)
         1:       return 2'b01;
         2:       return 2'b10;
         4:       return 2'b00;
         default: return 2'b11;
      endcase
   endfunction

   task automatic model_start(input logic [1:0] op, input logic [1:0] pt, input bit bu,
                              input bit wr, input logic [31:0] ad, input logic [OPW-1:0] wd);
      int pb;
      m_ob    = (op == 2'd3) ? 16 : (1 << op);
      pb      = (pt == 2'd0) ? 1 : (pt == 2'd1) ? 2 : 4;
      m_bb    = (m_ob < pb) ? m_ob : pb;
      m_beats = m_ob / m_bb;
      e_siz   = code_of(bu ? m_ob : m_bb);
      for (int i = 0; i < m_beats; i++) begin
         logic [31:0] d;
         d = '0;
         if (op == 2'd3)
            e_addr[i] = (ad & ~32'hF) | (((ad & 32'hC) + 32'(i * m_bb)) & 32'hF);
         else
            e_addr[i] = ad + 32'(i * m_bb);
         for (int j = 0; j < m_bb; j++)
            d[8*(3-j) +: 8] = wd[8*(m_ob-1-(i*m_bb+j)) +: 8];
         e_dout[i] = d;
      end
      m_run = 1; m_idx = 0; m_ts = 1; m_rdata = '0; m_wr = wr; m_bu = bu;
   endtask

   // compare this cycle, drive the next, advance the model across the coming edge
   task automatic tick(input bit rv, input logic [1:0] op, input logic [1:0] pt, input bit bu,
                       input bit wr, input logic [31:0] ad, input logic [OPW-1:0] wd,
                       input bit ta, input logic [31:0] din);
      bit nd;
      chk(bus_act == m_run, m_run ? "R3 beat count" : "R2 idle", OPW'(bus_act), OPW'(m_run));
      chk(req_rdy == !m_run, "R2 ready", OPW'(req_rdy), OPW'(!m_run));
      chk(rsp_done == m_done, "R10 done", OPW'(rsp_done), OPW'(m_done));
      if (m_done) chk(rsp_rdata == e_rdata, "R9 rdata", rsp_rdata, e_rdata);
      if (m_run && bus_act) begin
         chk(bus_addr == e_addr[m_idx], m_waited ? "R4 addr hold" : "R5 addr", OPW'(bus_addr), OPW'(e_addr[m_idx]));
         chk(bus_siz == e_siz, m_bu ? "R6 siz" : "R7 siz", OPW'(bus_siz), OPW'(e_siz));
         chk(bus_rw == !m_wr, "R12 rw", OPW'(bus_rw), OPW'(!m_wr));
         chk(bus_ts == m_ts, "R11 ts", OPW'(bus_ts), OPW'(m_ts));
         chk(bus_doe == m_wr, "R8 doe", OPW'(bus_doe), OPW'(m_wr));
         chk(bus_dout == (m_wr ? e_dout[m_idx] : 32'h0), m_waited ? "R4 data hold" : "R8 dout",
             OPW'(bus_dout), OPW'(m_wr ? e_dout[m_idx] : 32'h0));
      end
      req_valid = rv; req_op = op; req_port = pt; req_burst = bu; req_write = wr;
      req_addr = ad; req_wdata = wd; bus_ta_n = ta; bus_din = din;
      nd = 0;
      if (!m_run) begin
         m_waited = 0;
         if (rv) model_start(op, pt, bu, wr, ad, wd);
      end else if (!ta) begin
         m_waited = 0;
         if (!m_wr)
            for (int j = 0; j < m_bb; j++)
               m_rdata[8*(m_ob-1-(m_idx*m_bb+j)) +: 8] = din[8*(3-j) +: 8];
         if (m_idx == m_beats - 1) begin
            m_run = 0; nd = 1; e_rdata = m_rdata;
         end else begin
            m_idx++; m_ts = 1;
         end
      end else begin
         m_ts = 0; m_waited = 1;
      end
      m_done = nd;
      @(negedge clk);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_act == 1'b0, "R1 act", OPW'(bus_act), '0);
      chk(bus_doe == 1'b0, "R1 doe", OPW'(bus_doe), '0);
      chk(rsp_done == 1'b0, "R1 done", OPW'(rsp_done), '0);
      chk(req_rdy == 1'b1, "R1 rdy", OPW'(req_rdy), OPW'(1));
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_act == 1'b0 && req_rdy == 1'b1, "R1 after release", OPW'({bus_act, req_rdy}), OPW'(1));
      n = 0;
      for (int op = 0; op < 4; op++)
         for (int pt = 0; pt < 4; pt++)
            for (int bu = 0; bu < 2; bu++)
               for (int wr = 0; wr < 2; wr++) begin
                  logic [31:0] ad;
                  logic [OPW-1:0] wd;
                  ad = 32'h2000_0000 + 32'(n * 32'h100);
                  case (op)
                     0: ad = ad + 32'(n % 16);
                     1: ad = ad + 32'((n % 8) * 2);
                     default: ad = ad + 32'((n % 4) * 4);
                  endcase
                  wd = {$urandom, $urandom, $urandom, $urandom};
                  tick(1'b1, 2'(op), 2'(pt), bu[0], wr[0], ad, wd, 1'b1, $urandom);
                  while (m_run)
                     tick(1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                          $urandom, {$urandom, $urandom, $urandom, $urandom},
                          ($urandom % 3) == 0, $urandom);
                  if (n % 3 == 0)
                     tick(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, '0, 1'b0, $urandom);
                  n++;
               end
      repeat (3) tick(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, '0, 1'b0, 32'h0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule